// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It holds the accumulator and a four-flag status register. The four flags are zero, subtract, half-carry and carry. On each cycle it combines the accumulator with an external operand under a 4-bit opcode. The new result and flag values are shown combinationally, and they are committed on the rising clock edge when the enable is high.

Flag state can be read in two ways. `flags_o` gives the flags as a 4-bit vector. `flag_byte_o` packs them into the upper nibble of a byte for a push to a stack or for a status read.

Opcode encoding: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement accumulator, 9 set carry, 10 complement carry. Codes 11 to 15 are reserved.

Top module: `acc_alu`

## Requirements
- R1: After the asynchronous reset, the accumulator, all four flags and the flag byte read zero.
- R2: The flag byte places zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4, and bits 3:0 read 0. `flags_o` holds the same four flags in the order {zero, subtract, half-carry, carry}, with zero as its most significant bit.
- R3: Add (0) and add-with-carry (1) write A+B to the accumulator. The carry flag is added in only for opcode 1. Carry is bit 8 of the 9-bit sum, half-carry is the carry out of bit 3, subtract is cleared, and zero is set when the 8-bit result is 0.
- R4: Subtract (2) and subtract-with-borrow (3) write A-B to the accumulator. The carry flag is subtracted only for opcode 3. Carry is set when A < B+borrow, half-carry is set when A[3:0] < B[3:0]+borrow, subtract is set, and zero follows the result.
- R5: Compare (4) sets the flags exactly as subtract (2) would, and it leaves the accumulator unchanged.
- R6: AND (5), OR (6) and XOR (7) write the bitwise result and set zero from it, and they clear subtract. AND sets half-carry and clears carry. OR and XOR clear both half-carry and carry.
- R7: Complement accumulator (8) inverts all eight bits and sets subtract and half-carry. Zero and carry keep their values.
- R8: Set carry (9) forces carry to 1 and clears subtract and half-carry. Zero and the accumulator are unchanged.
- R9: Complement carry (10) inverts carry and clears subtract and half-carry. Zero and the accumulator are unchanged.
- R10: While `en_i` is low, the accumulator and the flags hold, whatever the opcode.
- R11: Reserved opcodes 11 to 15 leave the accumulator and the flags unchanged even when `en_i` is high.
- R12: `res_o` and `next_flags_o` show, in the same cycle, the result and flags that the current opcode would produce from the present state. With `en_i` high, these values appear on `acc_o` and `flags_o` after the next rising edge, for every opcode that writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Commit the operation at the next rising edge |
| op_i | input | 4 | Opcode select |
| operand_i | input | 8 | Second operand B |
| acc_o | output | 8 | Accumulator register |
| flags_o | output | 4 | Flag register {zero, subtract, half-carry, carry} |
| flag_byte_o | output | 8 | Packed flag byte |
| res_o | output | 8 | Combinational result of the current opcode |
| next_flags_o | output | 4 | Combinational next flags of the current opcode |

## Verification
In one operation, the incoming carry can be consumed and can also cause both the nibble carry and the byte carry. This happens when add-with-carry or subtract-with-borrow meets an operand for which the carry alone pushes across both the bit-3 and bit-7 boundaries. The bench provokes it by loading 0xFF, setting carry, and adding zero with carry. The expected outcome is a zero result with zero, half-carry and carry all set. It also subtracts zero with borrow from 0x00, where it expects 0xFF with half-carry and carry set. The reference model computes every such case from the requirements, and the bench then covers the rest of the space with random operation streams.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_CP  = 4'd4;
  localparam logic [3:0] OP_AND = 4'd5;
  localparam logic [3:0] OP_OR  = 4'd6;
  localparam logic [3:0] OP_XOR = 4'd7;
  localparam logic [3:0] OP_CPL = 4'd8;
  localparam logic [3:0] OP_SCF = 4'd9;
  localparam logic [3:0] OP_CCF = 4'd10;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_INV = 2'd3
  } logic_sel_e;

  // MSB first: zero, subtract, half-carry, carry
  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o,
  output logic              carry_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] sum_w, dif_w, rhs_w;
  logic [HALF_W:0] nib_sum, nib_rhs;

  always_comb begin
    rhs_w   = {1'b0, b_i} + (DATA_W+1)'(cin_i);
    nib_rhs = {1'b0, b_i[HALF_W-1:0]} + (HALF_W+1)'(cin_i);
    sum_w   = {1'b0, a_i} + rhs_w;
    dif_w   = {1'b0, a_i} - rhs_w;
    nib_sum = {1'b0, a_i[HALF_W-1:0]} + nib_rhs;
    if (sub_i) begin
      res_o   = dif_w[DATA_W-1:0];
      half_o  = {1'b0, a_i[HALF_W-1:0]} < nib_rhs;
      carry_o = {1'b0, a_i} < rhs_w;
    end else begin
      res_o   = sum_w[DATA_W-1:0];
      half_o  = nib_sum[HALF_W];
      carry_o = sum_w[DATA_W];
    end
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_sel_e        sel_i,
  output logic [DATA_W-1:0] res_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_AND:  res_o[i] = a_i[i] & b_i[i];
        LG_OR:   res_o[i] = a_i[i] | b_i[i];
        LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = ~a_i[i];
      endcase
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [3:0]        flags_o,
  output logic [7:0]        flag_byte_o,
  output logic [DATA_W-1:0] res_o,
  output logic [3:0]        next_flags_o
);
  logic [DATA_W-1:0] acc_q;
  flags_t            flags_q, flags_d;
  logic [DATA_W-1:0] as_res, lg_res, res_d;
  logic              as_half, as_carry, with_c, is_sub;
  logic              wr_acc, wr_flg;
  logic_sel_e        lg_sel;

  assign with_c = (op_i == OP_ADC) || (op_i == OP_SBC);
  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CP);

  acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i     (acc_q),
    .b_i     (operand_i),
    .cin_i   (with_c & flags_q.c),
    .sub_i   (is_sub),
    .res_o   (as_res),
    .half_o  (as_half),
    .carry_o (as_carry)
  );

  always_comb begin
    unique case (op_i)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_INV;
    endcase
  end

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (acc_q),
    .b_i   (operand_i),
    .sel_i (lg_sel),
    .res_o (lg_res)
  );

  always_comb begin
    res_d   = acc_q;
    flags_d = flags_q;
    wr_acc  = 1'b0;
    wr_flg  = 1'b1;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        res_d   = as_res;
        flags_d = '{z: as_res == '0, n: 1'b0, h: as_half, c: as_carry};
        wr_acc  = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CP: begin
        res_d   = as_res;
        flags_d = '{z: as_res == '0, n: 1'b1, h: as_half, c: as_carry};
        wr_acc  = (op_i != OP_CP);
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d   = lg_res;
        flags_d = '{z: lg_res == '0, n: 1'b0, h: op_i == OP_AND, c: 1'b0};
        wr_acc  = 1'b1;
      end
      OP_CPL: begin
        res_d     = lg_res;
        flags_d.n = 1'b1;
        flags_d.h = 1'b1;
        wr_acc    = 1'b1;
      end
      OP_SCF, OP_CCF: begin
        flags_d.n = 1'b0;
        flags_d.h = 1'b0;
        flags_d.c = (op_i == OP_SCF) ? 1'b1 : ~flags_q.c;
      end
      default: wr_flg = 1'b0;  // reserved codes
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (en_i) begin
      if (wr_acc) acc_q   <= res_d;
      if (wr_flg) flags_q <= flags_d;
    end
  end

  assign acc_o        = acc_q;
  assign flags_o      = flags_q;
  assign flag_byte_o  = {flags_q, 4'b0000};
  assign res_o        = res_d;
  assign next_flags_o = flags_d;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [7:0]        flag_byte_o
);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o) && $stable(flag_byte_o));

  // R11
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i > OP_CCF |=> $stable(acc_o) && $stable(flag_byte_o));

  // R5
  cp_keep_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_CP |=> $stable(acc_o) && flag_byte_o[6]);

  // R3
  add_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_ADD || op_i == OP_ADC)
    |=> !flag_byte_o[6] && (flag_byte_o[7] == (acc_o == '0)));

  // R6
  and_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_AND
    |=> flag_byte_o[6:4] == 3'b010 && (flag_byte_o[7] == (acc_o == '0)));

  // R7
  cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_CPL
    |=> acc_o == ~$past(acc_o) && flag_byte_o[6:5] == 2'b11
        && flag_byte_o[7] == $past(flag_byte_o[7])
        && flag_byte_o[4] == $past(flag_byte_o[4]));

  // R8
  scf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_SCF
    |=> flag_byte_o[6:4] == 3'b001 && $stable(acc_o) && $stable(flag_byte_o[7]));

  // R9
  ccf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_CCF
    |=> flag_byte_o[4] != $past(flag_byte_o[4]) && flag_byte_o[6:5] == 2'b00
        && $stable(acc_o));

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] operand_i = 8'd0;
  logic [7:0] acc_o, flag_byte_o, res_o;
  logic [3:0] flags_o, next_flags_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  acc_alu dut (.*);

  typedef struct {
    logic [7:0] acc;
    logic [7:0] fb;
    logic [3:0] fl;
    string      req;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_err = 0;
  logic [7:0] m_acc = 8'd0;
  logic [3:0] m_fl  = 4'd0;  // {z,n,h,c}

  task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] b, input logic en, input string req);
    logic [7:0] res;
    logic [3:0] nf;
    logic       wr, cin, h, c;
    logic [8:0] s9;
    exp_t       e;
    cin = ((op == 4'd1) || (op == 4'd3)) ? m_fl[0] : 1'b0;
    res = m_acc; nf = m_fl; wr = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        s9  = {1'b0, m_acc} + {1'b0, b} + {8'd0, cin};
        res = s9[7:0];
        h   = ({1'b0, m_acc[3:0]} + {1'b0, b[3:0]} + {4'd0, cin}) > 5'd15;
        nf  = {res == 8'd0, 1'b0, h, s9[8]};
        wr  = 1'b1;
      end
      4'd2, 4'd3, 4'd4: begin
        res = m_acc - b - {7'd0, cin};
        h   = {1'b0, m_acc[3:0]} < ({1'b0, b[3:0]} + {4'd0, cin});
        c   = {1'b0, m_acc} < ({1'b0, b} + {8'd0, cin});
        nf  = {res == 8'd0, 1'b1, h, c};
        wr  = (op != 4'd4);
      end
      4'd5: begin res = m_acc & b; nf = {res == 8'd0, 3'b010}; wr = 1'b1; end
      4'd6: begin res = m_acc | b; nf = {res == 8'd0, 3'b000}; wr = 1'b1; end
      4'd7: begin res = m_acc ^ b; nf = {res == 8'd0, 3'b000}; wr = 1'b1; end
      4'd8: begin res = ~m_acc; nf = {m_fl[3], 2'b11, m_fl[0]}; wr = 1'b1; end
      4'd9:  nf = {m_fl[3], 3'b001};
      4'd10: nf = {m_fl[3], 2'b00, ~m_fl[0]};
      default: ;
    endcase
    @(negedge clk_i);
    en_i = en; op_i = op; operand_i = b;
    #1;
    // R12: combinational preview
    check(res_o == res && next_flags_o == nf, {req, " R12 preview"},
          {8'd0, res_o, next_flags_o}, {8'd0, res, nf});
    if (en) begin
      if (wr) m_acc = res;
      m_fl = nf;
    end
    e.acc = m_acc; e.fl = m_fl; e.fb = {m_fl, 4'b0000}; e.req = req;
    q.push_back(e);
  endtask

  task automatic load(input logic [7:0] v);
    run_op(4'd5, 8'd0, 1'b1, "R6 load-and");
    run_op(4'd6, v, 1'b1, "R6 load-or");
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(acc_o == e.acc && flag_byte_o == e.fb && flags_o == e.fl,
              {e.req, " R2 state"},
              {acc_o, flag_byte_o, flags_o}, {e.acc, e.fb, e.fl});
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(acc_o == 8'd0 && flag_byte_o == 8'd0 && flags_o == 4'd0, "R1 reset",
          {acc_o, flag_byte_o, flags_o}, 20'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(acc_o == 8'd0 && flag_byte_o == 8'd0, "R1 after release",
          {4'd0, acc_o, flag_byte_o}, 20'd0);

    load(8'h3A);
    run_op(4'd0, 8'h0F, 1'b1, "R3 add half-carry");
    load(8'h01);
    run_op(4'd0, 8'hFF, 1'b1, "R3 add wrap zero");
    run_op(4'd9, 8'h00, 1'b1, "R8 scf");
    run_op(4'd0, 8'h10, 1'b1, "R3 add ignores carry");
    run_op(4'd9, 8'h00, 1'b1, "R8 scf");
    run_op(4'd1, 8'h10, 1'b1, "R3 adc uses carry");
    // carry alone crosses both boundaries
    load(8'hFF);
    run_op(4'd9, 8'h00, 1'b1, "R8 scf");
    run_op(4'd1, 8'h00, 1'b1, "R3 adc carry-only wrap");
    load(8'h00);
    run_op(4'd9, 8'h00, 1'b1, "R8 scf");
    run_op(4'd3, 8'h00, 1'b1, "R4 sbc borrow-only");
    load(8'h50);
    run_op(4'd2, 8'h21, 1'b1, "R4 sub nibble borrow");
    run_op(4'd2, 8'h2F, 1'b1, "R4 sub to zero");
    run_op(4'd2, 8'h01, 1'b1, "R4 sub underflow");
    load(8'h44);
    run_op(4'd4, 8'h44, 1'b1, "R5 cp equal");
    run_op(4'd4, 8'h45, 1'b1, "R5 cp less");
    run_op(4'd7, 8'h44, 1'b1, "R6 xor self zero");
    load(8'hC3);
    run_op(4'd5, 8'h0F, 1'b1, "R6 and");
    run_op(4'd9, 8'h00, 1'b1, "R8 scf");
    run_op(4'd8, 8'h00, 1'b1, "R7 cpl keeps z c");
    run_op(4'd10, 8'h00, 1'b1, "R9 ccf clear");
    run_op(4'd10, 8'h00, 1'b1, "R9 ccf set");
    run_op(4'd0, 8'h77, 1'b0, "R10 disabled add");
    run_op(4'd8, 8'h00, 1'b0, "R10 disabled cpl");
    for (int k = 11; k < 16; k++) run_op(4'(k), 8'hA5, 1'b1, "R11 reserved");

    for (int i = 0; i < 400; i++)
      run_op(4'($urandom_range(0, 15)), 8'($urandom), ($urandom_range(0, 3) != 0), "R12 random");

    @(negedge clk_i);
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    finish_run();
  end

endmodule